// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is an SPI bus master that a processor drives through a small 32-bit register bus. Software puts the block in configuration mode, programs clock polarity, clock phase, bit order, word length (8 or 16 bits) and an integer clock divisor, then switches to active mode and writes words into a 4-deep transmit FIFO. The shifter sends each word on MOSI while it samples MISO, and it pushes every captured word into a 4-deep receive FIFO. Software reads those words back through the data register.

A programmable receive level raises a threshold flag once enough words are waiting. With its enable bit set, that flag drives the interrupt output, so software can send a burst of up to four words and sleep until all the replies are in. A buffer-clear bit flushes both FIFOs. A stop bit holds off new words. Chip select belongs to the host and is not driven here.

Top module: `spi_reg_master`

Register offsets: 0x00 master control, 0x04 control 0, 0x08 control 1, 0x14 status, 0x18 data. Unlisted offsets read as zero.

## Requirements
- R1: After reset, master control reads 0x40 (configuration mode), control 0 reads 0, control 1 reads 0x0208 (divisor 2, length 8), status reads 0x4 (idle, both fill counts zero), irq is 0 and sck is 0.
- R2: Master control bits 7:6 select the mode. Value 2'b10 selects active mode and any other value selects configuration mode. Words shift only in active mode, and leaving active mode abandons a word in flight without pushing it to the receive FIFO.
- R3: Writes to control 0 and control 1 take effect only in configuration mode. In active mode they leave the register contents unchanged.
- R4: A data write (offset 0x18) pushes its low 16 bits into the 4-entry transmit FIFO. It is dropped in configuration mode, and it is dropped when the FIFO already holds 4 words.
- R5: Reading the data register with the read strobe pops the oldest received word. A read of an empty receive FIFO returns 0 and leaves the fill count at 0.
- R6: Writing 1 to master control bit 0 empties both FIFOs and cancels any word in flight. The bit is not stored and reads back as 0.
- R7: While master control bit 1 (stop) is 1, no new word starts. Clearing it lets the queued words shift out.
- R8: A bit lasts n clocks, where n is control 1 bits 15:8 (values 0 and 1 act as 2). sck sits at its non-idle level for floor(n/2) clocks of each bit, and it rests at the polarity level (control 0 bit 0) between words.
- R9: With phase (control 0 bit 1) at 0, MOSI changes at the start of a bit and MISO is sampled on the leading sck edge. With phase at 1, MOSI changes on the leading edge and MISO is sampled on the trailing edge.
- R10: Control 0 bit 2 set to 1 sends and receives the most significant bit first. Set to 0, it sends and receives the least significant bit first.
- R11: Control 1 bits 4:0 equal to 16 select 16-bit words, and any other value selects 8-bit words. In 8-bit mode only bits 7:0 of a written word are sent, and received words read with bits 15:8 at zero.
- R12: Every word shifted out pushes exactly one captured word into the receive FIFO. A word does not start while the receive FIFO is full.
- R13: Status bit 14 is set when the receive fill count is at least the level (control 0 bits 13:12) plus one. Status bits 13:11 give the transmit fill count, bits 10:8 the receive fill count, and bit 2 is set when the shifter is idle and the transmit FIFO is empty. irq equals status bit 14 AND control 0 bit 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Register byte offset |
| busWe | input | 1 | Write strobe, one cycle per write |
| busRe | input | 1 | Read strobe; pops the receive FIFO when the data offset is addressed |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| irq | output | 1 | Receive-threshold interrupt |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The assertions assume that each bus access is a single-cycle strobe on a stable address, and that the write and read strobes are never both high in the same cycle. They also assume that configuration registers change only through the bus, so the shifter settings stay fixed for as long as a word is in flight. The bench drives exactly one access per task at the falling clock edge and drops its strobes on the next falling edge. It wires MISO to MOSI, optionally inverted, so that every captured word follows from the sent word. Divisors are kept small so that many random configurations fit in the run.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int BUS_W      = 32;
  localparam int ADDR_W     = 8;
  localparam int WORD_W     = 16;
  localparam int FIFO_DEPTH = 4;
  localparam int DIV_W      = 8;
  localparam int CNT_W      = $clog2(FIFO_DEPTH + 1);

  localparam logic [7:0] OFS_MCTL = 8'h00;
  localparam logic [7:0] OFS_CTL0 = 8'h04;
  localparam logic [7:0] OFS_CTL1 = 8'h08;
  localparam logic [7:0] OFS_STAT = 8'h14;
  localparam logic [7:0] OFS_DATA = 8'h18;

  localparam logic [1:0] MODE_CFG = 2'b01;
  localparam logic [1:0] MODE_ACT = 2'b10;

  // Strobes from the register control to the datapath
  typedef struct packed {
    logic              txPush;
    logic              rxPop;
    logic              clearAll;
    logic [WORD_W-1:0] txWord;
  } strobe_t;

  // Static shifter settings held in the register control
  typedef struct packed {
    logic             active;
    logic             stop;
    logic             cpol;
    logic             cpha;
    logic             msbFirst;
    logic             wide;
    logic [DIV_W-1:0] div;
  } shiftCfg_t;

  // Datapath state reported back for status and reads
  typedef struct packed {
    logic [CNT_W-1:0]  txCount;
    logic [CNT_W-1:0]  rxCount;
    logic              idle;
    logic [WORD_W-1:0] rxHead;
  } dpStatus_t;
endpackage

// File: rtl/spi_reg_fifo.sv
module spi_reg_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic doPush, doPop;

  assign full   = (count == CNT_W'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      count <= count + CNT_W'(doPush) - CNT_W'(doPop);
    end
  end

  always_ff @(posedge clk) begin
    if (doPush && !clear) mem[wrPtr] <= pushData;
  end

  assign headData = empty ? '0 : mem[rdPtr];

  // R4: a push into a full FIFO leaves it full
  a_r4_full_push_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (push && full && !pop && !clear) |=> (count == $past(count)));

  // R5: a pop from an empty FIFO changes nothing
  a_r5_empty_pop_stable: assert property (@(posedge clk) disable iff (!rstN)
    (pop && empty && !push && !clear) |=> (count == '0));

  a_r4_count_bounded: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));
endmodule

// File: rtl/spi_reg_dp.sv
module spi_reg_dp
  import spi_reg_pkg::*;
#(
  parameter int WDW   = WORD_W,
  parameter int DEPTH = FIFO_DEPTH,
  localparam int BIT_W = $clog2(WDW)
) (
  input  logic      clk,
  input  logic      rstN,
  input  strobe_t   strb,
  input  shiftCfg_t cfg,
  input  logic      miso,
  output logic      sck,
  output logic      mosi,
  output dpStatus_t stat
);
  logic [WDW-1:0]   txHead, rxHead;
  logic [CNT_W-1:0] txCount, rxCount;
  logic txFull, txEmpty, rxFull, rxEmpty;
  logic txPop, rxPush;

  logic             busy;
  logic [DIV_W-1:0] phCnt;
  logic [BIT_W-1:0] bitIdx;
  logic [WDW-1:0]   curWord, rxAcc, rxNext;

  logic [DIV_W-1:0] effDiv, activeLen, idleLen, samplePt;
  logic [BIT_W-1:0] lastBit, bitPos;
  logic sckActive, sampleNow, bitEnd, wordEnd, canStart, abortWord;

  spi_reg_fifo #(.WIDTH(WDW), .DEPTH(DEPTH)) txFifo (
    .clk(clk), .rstN(rstN), .clear(strb.clearAll),
    .push(strb.txPush), .pushData(strb.txWord), .pop(txPop),
    .headData(txHead), .count(txCount), .full(txFull), .empty(txEmpty)
  );

  spi_reg_fifo #(.WIDTH(WDW), .DEPTH(DEPTH)) rxFifo (
    .clk(clk), .rstN(rstN), .clear(strb.clearAll),
    .push(rxPush), .pushData(rxNext), .pop(strb.rxPop),
    .headData(rxHead), .count(rxCount), .full(rxFull), .empty(rxEmpty)
  );

  // Bit timing derived from the divisor
  always_comb begin
    effDiv    = (cfg.div < DIV_W'(2)) ? DIV_W'(2) : cfg.div;
    activeLen = effDiv >> 1;
    idleLen   = effDiv - activeLen;
    samplePt  = cfg.cpha ? activeLen : idleLen;
    sckActive = cfg.cpha ? (phCnt < activeLen) : (phCnt >= idleLen);
    lastBit   = cfg.wide ? BIT_W'(WDW - 1) : BIT_W'(WDW / 2 - 1);
    bitPos    = cfg.msbFirst ? (lastBit - bitIdx) : bitIdx;
  end

  always_comb begin
    sampleNow = busy && (phCnt == samplePt);
    bitEnd    = busy && (phCnt == effDiv - 1'b1);
    wordEnd   = bitEnd && (bitIdx == lastBit);
    abortWord = strb.clearAll || !cfg.active;
    canStart  = !busy && cfg.active && !cfg.stop && !txEmpty && !rxFull && !strb.clearAll;
    rxNext    = rxAcc;
    if (sampleNow) rxNext[bitPos] = miso;
  end

  assign txPop  = canStart;
  assign rxPush = wordEnd && !abortWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      phCnt   <= '0;
      bitIdx  <= '0;
      curWord <= '0;
      rxAcc   <= '0;
    end else if (abortWord) begin
      busy <= 1'b0;
    end else if (canStart) begin
      busy    <= 1'b1;
      phCnt   <= '0;
      bitIdx  <= '0;
      curWord <= txHead;
      rxAcc   <= '0;
    end else if (busy) begin
      rxAcc <= rxNext;
      if (bitEnd) begin
        phCnt <= '0;
        if (wordEnd) busy <= 1'b0;
        else         bitIdx <= bitIdx + 1'b1;
      end else begin
        phCnt <= phCnt + 1'b1;
      end
    end
  end

  assign sck  = busy ? (cfg.cpol ^ sckActive) : cfg.cpol;
  assign mosi = busy ? curWord[bitPos] : 1'b0;

  assign stat.txCount = txCount;
  assign stat.rxCount = rxCount;
  assign stat.idle    = !busy && txEmpty;
  assign stat.rxHead  = rxHead;

  logic unusedFlags;
  assign unusedFlags = txFull ^ rxEmpty;

  // R2: a word only begins while the block is active
  a_r2_start_only_active: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(cfg.active));

  // R12: captured words never overflow the receive FIFO
  a_r12_no_rx_overflow: assert property (@(posedge clk) disable iff (!rstN)
    rxPush |-> !rxFull);

  // R7: stop holds the shifter idle
  a_r7_stop_blocks_start: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cfg.stop) |=> !busy);

  // R8: the bit index moves only at a bit boundary
  a_r8_bit_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !bitEnd && !abortWord) |=> $stable(bitIdx));
endmodule

// File: rtl/spi_reg_ctrl.sv
module spi_reg_ctrl
  import spi_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [BUS_W-1:0]  busWdata,
  input  dpStatus_t         stat,
  output logic [BUS_W-1:0]  busRdata,
  output logic              irq,
  output strobe_t           strb,
  output shiftCfg_t         cfg
);
  logic             modeAct, stopReq;
  logic             cpol, cpha, msbFirst, rxIntEn;
  logic [1:0]       rxLevel;
  logic [DIV_W-1:0] div;
  logic [4:0]       lenField;
  logic             thrFlag;
  logic selMctl, selCtl0, selCtl1, selStat, selData;

  assign selMctl = (busAddr == ADDR_W'(OFS_MCTL));
  assign selCtl0 = (busAddr == ADDR_W'(OFS_CTL0));
  assign selCtl1 = (busAddr == ADDR_W'(OFS_CTL1));
  assign selStat = (busAddr == ADDR_W'(OFS_STAT));
  assign selData = (busAddr == ADDR_W'(OFS_DATA));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeAct  <= 1'b0;
      stopReq  <= 1'b0;
      cpol     <= 1'b0;
      cpha     <= 1'b0;
      msbFirst <= 1'b0;
      rxIntEn  <= 1'b0;
      rxLevel  <= 2'd0;
      div      <= DIV_W'(2);
      lenField <= 5'd8;
    end else if (busWe) begin
      if (selMctl) begin
        modeAct <= (busWdata[7:6] == MODE_ACT);
        stopReq <= busWdata[1];
      end
      if (selCtl0 && !modeAct) begin
        cpol     <= busWdata[0];
        cpha     <= busWdata[1];
        msbFirst <= busWdata[2];
        rxIntEn  <= busWdata[9];
        rxLevel  <= busWdata[13:12];
      end
      if (selCtl1 && !modeAct) begin
        div      <= busWdata[15:8];
        lenField <= busWdata[4:0];
      end
    end
  end

  always_comb begin
    strb.txPush   = busWe && selData && modeAct;
    strb.txWord   = busWdata[WORD_W-1:0];
    strb.rxPop    = busRe && selData;
    strb.clearAll = busWe && selMctl && busWdata[0];
  end

  always_comb begin
    cfg.active   = modeAct;
    cfg.stop     = stopReq;
    cfg.cpol     = cpol;
    cfg.cpha     = cpha;
    cfg.msbFirst = msbFirst;
    cfg.wide     = (lenField == 5'd16);
    cfg.div      = div;
  end

  assign thrFlag = (stat.rxCount > CNT_W'(rxLevel));
  assign irq     = thrFlag && rxIntEn;

  always_comb begin
    busRdata = '0;
    if (selMctl) begin
      busRdata[7:6] = modeAct ? MODE_ACT : MODE_CFG;
      busRdata[1]   = stopReq;
    end else if (selCtl0) begin
      busRdata[0]     = cpol;
      busRdata[1]     = cpha;
      busRdata[2]     = msbFirst;
      busRdata[9]     = rxIntEn;
      busRdata[13:12] = rxLevel;
    end else if (selCtl1) begin
      busRdata[15:8] = div;
      busRdata[4:0]  = lenField;
    end else if (selStat) begin
      busRdata[14]    = thrFlag;
      busRdata[13:11] = stat.txCount;
      busRdata[10:8]  = stat.rxCount;
      busRdata[2]     = stat.idle;
    end else if (selData) begin
      busRdata[WORD_W-1:0] = stat.rxHead;
    end
  end

  logic unusedBits;
  assign unusedBits = ^busWdata[BUS_W-1:WORD_W];

  // R3: control 0 is frozen while active
  a_r3_ctl0_locked: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && selCtl0 && modeAct) |=>
      ($stable(cpol) && $stable(cpha) && $stable(msbFirst) && $stable(rxLevel) && $stable(rxIntEn)));

  // R3: control 1 is frozen while active
  a_r3_ctl1_locked: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && selCtl1 && modeAct) |=> ($stable(div) && $stable(lenField)));

  // R4: data writes in configuration mode never grow the transmit FIFO
  a_r4_cfg_data_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && selData && !modeAct) |=> (stat.txCount <= $past(stat.txCount)));

  // R6: clearing leaves both FIFOs empty
  a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearAll |=> (stat.txCount == '0 && stat.rxCount == '0));

  // R13: the interrupt needs waiting words and its enable
  a_r13_irq_needs_data: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (stat.rxCount != '0 && rxIntEn));
endmodule

// File: rtl/spi_reg_master.sv
module spi_reg_master
  import spi_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  output logic              irq,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);
  strobe_t   strb;
  shiftCfg_t cfg;
  dpStatus_t stat;

  spi_reg_ctrl ctrlU (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
    .busWdata(busWdata), .stat(stat), .busRdata(busRdata), .irq(irq),
    .strb(strb), .cfg(cfg)
  );

  spi_reg_dp #(.WDW(WORD_W), .DEPTH(FIFO_DEPTH)) dpU (
    .clk(clk), .rstN(rstN), .strb(strb), .cfg(cfg), .miso(miso),
    .sck(sck), .mosi(mosi), .stat(stat)
  );
endmodule

// File: tb/spi_reg_master_tb_top.sv
module spi_reg_master_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] busAddr = '0;
  logic busWe = 1'b0, busRe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic irq, sck, mosi, miso;
  logic misoInv = 1'b0;

  int checks = 0, fails = 0, cycles = 0;
  bit curCpol, curCpha, curWide, curInv, monEn;
  int activeClk;
  logic prevSck = 1'b0;
  logic bitQ[$];
  logic [15:0] wbuf [5];
  logic [31:0] lastCtl0, lastCtl1;

  assign miso = mosi ^ misoInv;

  spi_reg_master dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq), .sck(sck),
    .mosi(mosi), .miso(miso)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<190000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // Serial monitor: records MOSI at every sampling edge
  always @(negedge clk) begin
    if (monEn) begin
      if (!curCpha && prevSck == curCpol && sck != curCpol) bitQ.push_back(mosi);
      if (curCpha && prevSck != curCpol && sck == curCpol) bitQ.push_back(mosi);
      if (sck != curCpol) activeClk++;
    end
    prevSck = sck;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, input logic pop, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRe = pop;
    #9;
    d = busRdata;
    @(negedge clk);
    busRe = 1'b0;
  endtask

  function automatic int effDivF(input int d);
    return (d < 2) ? 2 : d;
  endfunction

  function automatic logic [15:0] rxExpect(input logic [15:0] w, input bit wide, input bit inv);
    logic [15:0] v;
    v = inv ? ~w : w;
    return wide ? v : {8'h00, v[7:0]};
  endfunction

  task automatic waitRx(input int k, input string req);
    logic [31:0] s;
    bit done = 0;
    for (int i = 0; i < 5000 && !done; i++) begin
      busRead(8'h14, 1'b0, s);
      if (s[2] && s[10:8] == 3'(k)) done = 1;
    end
    chk({req, " words completed"}, {31'd0, done}, 32'd1);
  endtask

  task automatic runXfer(input bit cpol, input bit cpha, input bit msb, input bit wide,
                         input int div, input int lvl, input bit ien, input int k,
                         input bit inv);
    logic [31:0] s, d;
    int wl, mism, idx;
    bit flag;
    monEn = 0;
    busWrite(8'h00, 32'h40);
    lastCtl0 = (lvl << 12) | (ien << 9) | (msb << 2) | (cpha << 1) | cpol;
    lastCtl1 = ((div & 255) << 8) | (wide ? 16 : 8);
    busWrite(8'h04, lastCtl0);
    busWrite(8'h08, lastCtl1);
    curCpol = cpol; curCpha = cpha; curWide = wide; curInv = inv;
    misoInv = inv;
    @(negedge clk);
    bitQ.delete();
    activeClk = 0;
    monEn = 1;
    busWrite(8'h00, 32'h80);
    for (int i = 0; i < k; i++) busWrite(8'h18, {16'hABCD, wbuf[i]});
    waitRx(k, "R12");
    busRead(8'h14, 1'b0, s);
    chk("R12 one capture per word", {29'd0, s[10:8]}, k);
    flag = (k >= lvl + 1);
    chk("R13 threshold flag", {31'd0, s[14]}, {31'd0, flag});
    chk("R13 irq", {31'd0, irq}, {31'd0, flag && ien});
    wl = wide ? 16 : 8;
    chk("R9 R10 serial bit count", bitQ.size(), k * wl);
    mism = 0;
    if (bitQ.size() == k * wl) begin
      idx = 0;
      for (int i = 0; i < k; i++)
        for (int b = 0; b < wl; b++) begin
          if (bitQ[idx] !== wbuf[i][msb ? (wl - 1 - b) : b]) mism++;
          idx++;
        end
    end
    chk("R10 R11 serial bit order", mism, 0);
    chk("R8 active sck clocks", activeClk, k * wl * (effDivF(div) / 2));
    monEn = 0;
    for (int i = 0; i < k; i++) begin
      busRead(8'h18, 1'b1, d);
      chk("R11 R12 received word", d, {16'd0, rxExpect(wbuf[i], wide, inv)});
    end
    busRead(8'h14, 1'b0, s);
    chk("R5 rx drained", {29'd0, s[10:8]}, 0);
  endtask

  initial begin
    logic [31:0] r;
    int seedDummy;
    seedDummy = $urandom(32'd5150);
    monEn = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    busRead(8'h00, 1'b0, r); chk("R1 master control", r, 32'h40);
    busRead(8'h04, 1'b0, r); chk("R1 control 0", r, 32'h0);
    busRead(8'h08, 1'b0, r); chk("R1 control 1", r, 32'h0208);
    busRead(8'h14, 1'b0, r); chk("R1 status", r, 32'h4);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 sck", {31'd0, sck}, 0);

    // R4 data write in configuration mode is dropped
    busWrite(8'h18, 32'h55);
    busRead(8'h14, 1'b0, r); chk("R4 config data dropped", {29'd0, r[13:11]}, 0);

    // Directed transfers
    wbuf[0] = 16'h00A5; wbuf[1] = 16'h003C; wbuf[2] = 16'hFF81;
    runXfer(0, 0, 1, 0, 4, 1, 1, 3, 0);
    wbuf[0] = 16'hBEEF; wbuf[1] = 16'h1234;
    runXfer(1, 1, 0, 1, 5, 3, 1, 2, 1);

    // R3 control writes ignored while active
    busWrite(8'h04, 32'h0000_3FFF);
    busRead(8'h04, 1'b0, r); chk("R3 control 0 locked", r, lastCtl0);
    busWrite(8'h08, 32'h0000_7710);
    busRead(8'h08, 1'b0, r); chk("R3 control 1 locked", r, lastCtl1);

    // R7 stop, R4 full transmit FIFO
    busWrite(8'h00, 32'h82);
    for (int i = 0; i < 5; i++) begin
      wbuf[i] = 16'(16'h1111 * (i + 1));
      busWrite(8'h18, {16'h0, wbuf[i]});
    end
    busRead(8'h14, 1'b0, r);
    chk("R4 tx full count", {29'd0, r[13:11]}, 4);
    chk("R7 no word while stopped", {29'd0, r[10:8]}, 0);
    busWrite(8'h00, 32'h80);
    waitRx(4, "R7");
    for (int i = 0; i < 4; i++) begin
      busRead(8'h18, 1'b1, r);
      chk("R4 kept words", r, {16'd0, rxExpect(wbuf[i], curWide, curInv)});
    end

    // R5 pop of empty FIFO
    busRead(8'h18, 1'b1, r); chk("R5 empty pop reads zero", r, 0);
    busRead(8'h14, 1'b0, r); chk("R5 empty pop count", {29'd0, r[10:8]}, 0);

    // R6 buffer clear
    busWrite(8'h18, 32'h1); busWrite(8'h18, 32'h2);
    waitRx(2, "R6");
    busWrite(8'h00, 32'h82);
    for (int i = 0; i < 3; i++) busWrite(8'h18, 32'h9);
    busWrite(8'h00, 32'h83);
    busRead(8'h14, 1'b0, r);
    chk("R6 tx cleared", {29'd0, r[13:11]}, 0);
    chk("R6 rx cleared", {29'd0, r[10:8]}, 0);
    busRead(8'h00, 1'b0, r); chk("R6 clear bit not stored", r, 32'h82);

    // R2 mode decode
    busWrite(8'h00, 32'hC0);
    busRead(8'h00, 1'b0, r); chk("R2 mode 11 is config", r, 32'h40);
    busWrite(8'h18, 32'h7);
    busRead(8'h14, 1'b0, r); chk("R2 R4 no push in config", {29'd0, r[13:11]}, 0);
    busWrite(8'h00, 32'h00);
    busRead(8'h00, 1'b0, r); chk("R2 mode 00 is config", r, 32'h40);

    // R2 leaving active abandons the word in flight
    busWrite(8'h04, 32'h0);
    busWrite(8'h08, 32'h0000_C810);
    busWrite(8'h00, 32'h80);
    busWrite(8'h18, 32'h5A5A);
    repeat (30) @(negedge clk);
    busWrite(8'h00, 32'h40);
    repeat (4000) @(negedge clk);
    busRead(8'h14, 1'b0, r);
    chk("R2 abandoned word not captured", {29'd0, r[10:8]}, 0);
    chk("R2 idle after abandon", {31'd0, r[2]}, 1);
    chk("R8 sck at polarity when idle", {31'd0, sck}, 0);

    // R8 divisor 1 acts as 2
    wbuf[0] = 16'h0F0F;
    runXfer(0, 1, 1, 1, 1, 0, 0, 1, 0);

    // Random configurations
    for (int it = 0; it < 25; it++) begin
      int k;
      k = 1 + int'($urandom_range(0, 3));
      for (int i = 0; i < 4; i++) wbuf[i] = 16'($urandom());
      runXfer(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              int'($urandom_range(0, 12)), int'($urandom_range(0, 3)),
              1'($urandom_range(0, 1)), k, 1'($urandom_range(0, 1)));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule